// File: doc/BRIEF.md
# Text display generator

This block turns a character screen held in video memory into a serial pixel stream. It walks a grid of text cells in raster order: the column changes fastest, then the scan line within the text row, then the text row. Each cell is 8 pixels wide and takes 8 clock cycles, one pixel per clock. For every cell the block reads a character code from video RAM and a byte from a timing ROM. It then reads the glyph byte for the current scan line from a character ROM and shifts it out, most significant bit first.

The timing ROM supplies the blanking and horizontal sync bits for each cell. It is addressed one row and one column ahead of the cell being drawn. Bit 7 of the character code has one of two meanings, chosen by a control byte. In 256-character mode it selects the upper glyph bank, and one global inverse bit acts on every cell. In 128-character mode it inverts the pixels of that cell only. The control byte also carries a beep enable, which is passed out as a level.

All three memories are external and have a synchronous read port with one cycle of latency. The block issues the reads inside each cell's 8 cycles. The pixel, blank, sync and frame-start outputs come out together, 8 cycles after the cell starts.

Top module: `txtvid_gen`

## Requirements
- R1: After reset, and for the first 8 cycles after reset is released, pix_o=0, blank_o=1, hsync_o=0 and frame_o=0. Cell (row 0, scan 0, column 0) starts in the first cycle after reset is released.
- R2: Cells follow one another every 8 cycles in this order: column 0..COLS-1 fastest, then scan line 0..SCANS-1, then row 0..ROWS-1, then back to the start. In the second cycle of each cell, vram_addr = (row << COL_W) | column.
- R3: The timing ROM address for a cell is ((row + 1) << COL_W) + column + 1, truncated to TIM_W bits. Its bit 4 is the blank bit and its bit 6 is the sync bit. A cell whose blank bit is 1 outputs 8 zero pixels with blank_o=1. hsync_o carries bit 6 for all 8 pixels of the cell.
- R4: In 256-character mode the glyph address is {code[7], scan, code[6:0]}, and every cell is inverted when the alternate bit is active.
- R5: In 128-character mode the glyph address is {0, scan, code[6:0]}, and a cell is inverted when its code[7] is 1.
- R6: The glyph byte is output from bit 7 down to bit 0. Pixel k of a cell appears on pix_o 8+k cycles after the cell's first cycle.
- R7: The control byte is taken in the first cycle of each cell and applies to that whole cell. Bit 4 = 0 selects 256-character mode. Bit 3 = 0 makes the alternate (inverse) bit active. Changes later in the cell have no effect on that cell.
- R8: frame_o is high for exactly one cycle per frame, in the cycle that shows pixel 0 of cell (row 0, scan 0, column 0).
- R9: beep_o equals the inverse of control bit 5 from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 8 | Control byte: bit 3 alternate (active low), bit 4 256-character mode (active low), bit 5 beep (active low) |
| vram_addr | output | VA_W | Video RAM read address |
| vram_data | input | 8 | Character code, one cycle after the address |
| tim_addr | output | TIM_W | Timing ROM read address |
| tim_data | input | 8 | Timing byte, one cycle after the address |
| font_addr | output | FA_W | Character ROM read address |
| font_data | input | 8 | Glyph byte, one cycle after the address |
| pix_o | output | 1 | Serial pixel |
| blank_o | output | 1 | Blank flag aligned with pix_o |
| hsync_o | output | 1 | Sync flag aligned with pix_o |
| frame_o | output | 1 | One-cycle frame-start pulse aligned with pix_o |
| beep_o | output | 1 | Beep enable level |

## Verification
The assertions assume that each memory returns data exactly one cycle after its address. They also assume COLS fits in the COL_W column field, and that the control byte holds no X once reset is released. The bench's memory models are registered one-cycle lookups computed from the address. The bench changes the control byte at arbitrary cycles, including the middle of cells. The reference model then uses only the value present in each cell's first cycle, which is the assumption the block works under.

// File: rtl/txv_pkg.sv
package txv_pkg;
  localparam int CELL_PIX = 8;
  localparam int PHASE_W  = 3;

  localparam logic [PHASE_W-1:0] PH_ISSUE = 3'd0;
  localparam logic [PHASE_W-1:0] PH_CODE  = 3'd2;
  localparam logic [PHASE_W-1:0] PH_GLYPH = 3'd4;
  localparam logic [PHASE_W-1:0] PH_LOAD  = 3'd7;

  localparam int BLANK_BIT = 4;
  localparam int SYNC_BIT  = 6;

  typedef struct packed {
    logic wide;
    logic alt;
  } charset_t;

  function automatic charset_t decode_ctrl(input logic [7:0] c);
    charset_t r;
    r.wide = ~c[4];
    r.alt  = ~c[3];
    return r;
  endfunction
endpackage

// File: rtl/txv_raster.sv
module txv_raster #(
  parameter int COLS   = 128,
  parameter int ROWS   = 26,
  parameter int SCANS  = 10,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 5,
  parameter int SCAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [2:0]        phase,
  output logic [COL_W-1:0]  col,
  output logic [SCAN_W-1:0] scan,
  output logic [ROW_W-1:0]  row,
  output logic              origin
);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCANS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic [2:0]        phase_q;
  logic [COL_W-1:0]  col_q;
  logic [SCAN_W-1:0] scan_q;
  logic [ROW_W-1:0]  row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      col_q   <= '0;
      scan_q  <= '0;
      row_q   <= '0;
    end else begin
      phase_q <= phase_q + 3'd1;
      if (phase_q == 3'd7) begin
        if (col_q == COL_LAST) begin
          col_q <= '0;
          if (scan_q == SCAN_LAST) begin
            scan_q <= '0;
            if (row_q == ROW_LAST) row_q <= '0;
            else                   row_q <= row_q + 1'b1;
          end else begin
            scan_q <= scan_q + 1'b1;
          end
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign phase  = phase_q;
  assign col    = col_q;
  assign scan   = scan_q;
  assign row    = row_q;
  assign origin = ~|{phase_q, col_q, scan_q, row_q};
endmodule

// File: rtl/txv_fetch.sv
module txv_fetch
  import txv_pkg::*;
#(
  parameter int COL_W  = 7,
  parameter int ROW_W  = 5,
  parameter int SCAN_W = 4,
  parameter int TIM_W  = 12,
  parameter int VA_W   = ROW_W + COL_W,
  parameter int FA_W   = SCAN_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        phase,
  input  logic [COL_W-1:0]  col,
  input  logic [SCAN_W-1:0] scan,
  input  logic [ROW_W-1:0]  row,
  input  logic              origin,
  input  logic [7:0]        ctrl,
  input  logic [7:0]        vram_data,
  input  logic [7:0]        tim_data,
  output logic [VA_W-1:0]   vram_addr,
  output logic [TIM_W-1:0]  tim_addr,
  output logic [FA_W-1:0]   font_addr,
  output logic              code7,
  output logic              wide,
  output logic              alt,
  output logic              blank,
  output logic              hsync,
  output logic              origin_s
);
  localparam logic [31:0]      TIM_ORIGIN_32 = (32'd1 << COL_W) + 32'd1;
  localparam logic [TIM_W-1:0] TIM_ORIGIN    = TIM_ORIGIN_32[TIM_W-1:0];

  logic [VA_W-1:0]   va_q;
  logic [TIM_W-1:0]  ta_q;
  logic [FA_W-1:0]   fa_q;
  logic [SCAN_W-1:0] scan_s;
  charset_t          cs_s;
  logic              org_q;
  logic              code7_q;
  logic              blank_q;
  logic              hs_q;

  logic [31:0]       tim_sum;
  logic [TIM_W-1:0]  tim_next;
  logic [FA_W-1:0]   fa_next;
  logic              unused_fetch;

  always_comb begin
    tim_sum  = ((32'(row) + 32'd1) << COL_W) + 32'(col) + 32'd1;
    tim_next = tim_sum[TIM_W-1:0];
    fa_next  = {vram_data[7] & cs_s.wide, scan_s, vram_data[6:0]};
  end

  assign unused_fetch = ^{ctrl[7:5], ctrl[2:0], tim_data[7], tim_data[5], tim_data[3:0]};

  // Stage 1: issue video RAM and timing ROM reads, capture cell attributes
  always_ff @(posedge clk) begin
    if (rst) begin
      va_q   <= '0;
      ta_q   <= TIM_ORIGIN;
      scan_s <= '0;
      cs_s   <= '0;
      org_q  <= 1'b0;
    end else if (phase == PH_ISSUE) begin
      va_q   <= {row, col};
      ta_q   <= tim_next;
      scan_s <= scan;
      cs_s   <= decode_ctrl(ctrl);
      org_q  <= origin;
    end
  end

  // Stage 2: take code and timing byte, issue glyph read
  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q    <= '0;
      code7_q <= 1'b0;
      blank_q <= 1'b1;
      hs_q    <= 1'b0;
    end else if (phase == PH_CODE) begin
      fa_q    <= fa_next;
      code7_q <= vram_data[7];
      blank_q <= tim_data[BLANK_BIT];
      hs_q    <= tim_data[SYNC_BIT];
    end
  end

  assign vram_addr = va_q;
  assign tim_addr  = ta_q;
  assign font_addr = fa_q;
  assign code7     = code7_q;
  assign wide      = cs_s.wide;
  assign alt       = cs_s.alt;
  assign blank     = blank_q;
  assign hsync     = hs_q;
  assign origin_s  = org_q;
endmodule

// File: rtl/txv_serial.sv
module txv_serial
  import txv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] phase,
  input  logic [7:0] font_data,
  input  logic       code7,
  input  logic       wide,
  input  logic       alt,
  input  logic       blank,
  input  logic       hsync,
  input  logic       origin,
  output logic       pix_o,
  output logic       blank_o,
  output logic       hsync_o,
  output logic       frame_o
);
  logic [CELL_PIX-1:0] hold_q;
  logic                hold_blk;
  logic                hold_hs;
  logic                hold_org;
  logic [CELL_PIX-1:0] sh_q;
  logic                blk_q;
  logic                hs_q;
  logic                frm_q;
  logic                inv;
  logic [CELL_PIX-1:0] glyph;

  always_comb begin
    inv   = wide ? alt : code7;
    glyph = blank ? '0 : (font_data ^ {CELL_PIX{inv}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      hold_blk <= 1'b1;
      hold_hs  <= 1'b0;
      hold_org <= 1'b0;
    end else if (phase == PH_GLYPH) begin
      hold_q   <= glyph;
      hold_blk <= blank;
      hold_hs  <= hsync;
      hold_org <= origin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      blk_q <= 1'b1;
      hs_q  <= 1'b0;
      frm_q <= 1'b0;
    end else if (phase == PH_LOAD) begin
      sh_q  <= hold_q;
      blk_q <= hold_blk;
      hs_q  <= hold_hs;
      frm_q <= hold_org;
    end else begin
      sh_q  <= {sh_q[CELL_PIX-2:0], 1'b0};
      frm_q <= 1'b0;
    end
  end

  assign pix_o   = sh_q[CELL_PIX-1];
  assign blank_o = blk_q;
  assign hsync_o = hs_q;
  assign frame_o = frm_q;
endmodule

// File: rtl/txtvid_gen.sv
module txtvid_gen #(
  parameter  int COLS   = 128,
  parameter  int ROWS   = 26,
  parameter  int SCANS  = 10,
  parameter  int COL_W  = 7,
  parameter  int TIM_W  = 12,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SCAN_W = (SCANS > 1) ? $clog2(SCANS) : 1,
  localparam int VA_W   = ROW_W + COL_W,
  localparam int FA_W   = SCAN_W + 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       ctrl,
  output logic [VA_W-1:0]  vram_addr,
  input  logic [7:0]       vram_data,
  output logic [TIM_W-1:0] tim_addr,
  input  logic [7:0]       tim_data,
  output logic [FA_W-1:0]  font_addr,
  input  logic [7:0]       font_data,
  output logic             pix_o,
  output logic             blank_o,
  output logic             hsync_o,
  output logic             frame_o,
  output logic             beep_o
);
  logic [2:0]        phase;
  logic [COL_W-1:0]  col;
  logic [SCAN_W-1:0] scan;
  logic [ROW_W-1:0]  row;
  logic              origin;
  logic              code7, wide, alt, blank, hsync, origin_s;
  logic              beep_q;

  txv_raster #(
    .COLS(COLS), .ROWS(ROWS), .SCANS(SCANS),
    .COL_W(COL_W), .ROW_W(ROW_W), .SCAN_W(SCAN_W)
  ) u_raster (
    .clk(clk), .rst(rst), .phase(phase), .col(col),
    .scan(scan), .row(row), .origin(origin)
  );

  txv_fetch #(
    .COL_W(COL_W), .ROW_W(ROW_W), .SCAN_W(SCAN_W),
    .TIM_W(TIM_W), .VA_W(VA_W), .FA_W(FA_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .phase(phase), .col(col), .scan(scan),
    .row(row), .origin(origin), .ctrl(ctrl),
    .vram_data(vram_data), .tim_data(tim_data),
    .vram_addr(vram_addr), .tim_addr(tim_addr), .font_addr(font_addr),
    .code7(code7), .wide(wide), .alt(alt), .blank(blank),
    .hsync(hsync), .origin_s(origin_s)
  );

  txv_serial u_serial (
    .clk(clk), .rst(rst), .phase(phase), .font_data(font_data),
    .code7(code7), .wide(wide), .alt(alt), .blank(blank),
    .hsync(hsync), .origin(origin_s),
    .pix_o(pix_o), .blank_o(blank_o), .hsync_o(hsync_o), .frame_o(frame_o)
  );

  always_ff @(posedge clk) begin
    beep_q <= ~ctrl[5];
  end

  assign beep_o = beep_q;
endmodule

// File: rtl/txtvid_gen_chk.sv
module txtvid_gen_chk #(
  parameter int COLS  = 128,
  parameter int COL_W = 7,
  parameter int TIM_W = 12,
  parameter int VA_W  = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             beep_src,
  input logic [VA_W-1:0]  vram_addr,
  input logic [TIM_W-1:0] tim_addr,
  input logic             pix_o,
  input logic             blank_o,
  input logic             frame_o,
  input logic             beep_o
);
  function automatic logic [TIM_W-1:0] tim_of(input logic [VA_W-1:0] va);
    logic [31:0] s;
    s = ((32'(va) >> COL_W) + 32'd1) << COL_W;
    s = s + 32'(va[COL_W-1:0]) + 32'd1;
    return s[TIM_W-1:0];
  endfunction

  // R2: the column field never exceeds the last column
  a_r2_col_range: assert property (@(posedge clk) disable iff (rst)
    vram_addr[COL_W-1:0] <= COL_W'(COLS - 1));

  // R3: the timing address is one row and one column ahead of the cell
  a_r3_tim_offset: assert property (@(posedge clk) disable iff (rst)
    tim_addr == tim_of(vram_addr));

  // R3: a blanked pixel is dark
  a_r3_blank_dark: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> !pix_o);

  // R8: the frame pulse lasts one cycle
  a_r8_frame_single: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);

  // R9: beep follows the inverted control bit one cycle later
  a_r9_beep_level: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (beep_o == !$past(beep_src)));
endmodule

bind txtvid_gen txtvid_gen_chk #(
  .COLS(COLS), .COL_W(COL_W), .TIM_W(TIM_W), .VA_W(VA_W)
) u_chk (
  .clk(clk), .rst(rst), .beep_src(ctrl[5]), .vram_addr(vram_addr),
  .tim_addr(tim_addr), .pix_o(pix_o), .blank_o(blank_o),
  .frame_o(frame_o), .beep_o(beep_o)
);

// File: tb/txtvid_gen_tb.sv
`timescale 1ns/1ps
module txtvid_gen_tb;
  localparam int COLS  = 8;
  localparam int ROWS  = 3;
  localparam int SCANS = 10;
  localparam int COL_W = 7;
  localparam int TIM_W = 12;
  localparam int VA_W  = 2 + COL_W;
  localparam int FA_W  = 4 + 8;
  localparam int FRAME = COLS * ROWS * SCANS * 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       ctrl = 8'h18;
  logic [VA_W-1:0]  vram_addr;
  logic [7:0]       vram_data = 8'h00;
  logic [TIM_W-1:0] tim_addr;
  logic [7:0]       tim_data = 8'h00;
  logic [FA_W-1:0]  font_addr;
  logic [7:0]       font_data = 8'h00;
  logic             pix_o, blank_o, hsync_o, frame_o, beep_o;

  always #10 clk = ~clk;

  txtvid_gen #(
    .COLS(COLS), .ROWS(ROWS), .SCANS(SCANS), .COL_W(COL_W), .TIM_W(TIM_W)
  ) u_dut (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .vram_addr(vram_addr), .vram_data(vram_data),
    .tim_addr(tim_addr), .tim_data(tim_data),
    .font_addr(font_addr), .font_data(font_data),
    .pix_o(pix_o), .blank_o(blank_o), .hsync_o(hsync_o),
    .frame_o(frame_o), .beep_o(beep_o)
  );

  // memory contents, defined by the bench
  function automatic logic [7:0] vram_fn(input int a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic logic [7:0] font_fn(input int a);
    return 8'((a * 13) ^ (a >> 3));
  endfunction
  function automatic logic [7:0] tim_fn(input int a);
    logic [7:0] t;
    t = 8'h00;
    if ((a % 128) >= 7 || (a / 128) == 3) t[4] = 1'b1;
    if ((a % 128) == 3) t[6] = 1'b1;
    return t;
  endfunction

  always @(posedge clk) begin
    vram_data <= vram_fn(int'(vram_addr));
    tim_data  <= tim_fn(int'(tim_addr));
    font_data <= font_fn(int'(font_addr));
  end

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // reference model: entry = tag*16 + {fs,hs,blk,pix}
  int exq[$];
  int r = 0, s = 0, c = 0, b = 0;
  int va_exp = 0;
  bit va_chk = 0;
  bit beep_exp = 0;
  bit beep_vld = 0;
  int fs_seen = 0, fs_exp = 0;

  function automatic string tagname(input int t);
    case (t)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    beep_exp = !ctrl[5];
    beep_vld = 1;
    if (rst) begin
      exq.delete();
      for (int i = 0; i < 8; i++) exq.push_back(1 * 16 + 4'b0010);
      r = 0; s = 0; c = 0; b = 0;
      va_chk = 0;
    end else begin
      if (b == 0) begin
        logic [7:0]  code, tm, g;
        logic [11:0] fa;
        bit m256, altv, inv;
        int ta, tag;
        code = vram_fn((r << 7) | c);
        ta   = (((r + 1) << 7) + c + 1) & 12'hFFF;
        tm   = tim_fn(ta);
        m256 = !ctrl[4];
        altv = !ctrl[3];
        fa   = {code[7] & m256, 4'(s), code[6:0]};
        g    = font_fn(int'(fa));
        inv  = m256 ? altv : code[7];
        if (tm[4]) g = 8'h00;
        else if (inv) g = ~g;
        tag = tm[4] ? 3 : (m256 ? 4 : 5);
        for (int k = 0; k < 8; k++) begin
          int e;
          e = tag * 16;
          if (g[7 - k]) e += 1;
          if (tm[4]) e += 2;
          if (tm[6]) e += 4;
          if (k == 0 && r == 0 && s == 0 && c == 0) e += 8;
          exq.push_back(e);
        end
        va_exp = (r << 7) | c;
        va_chk = 1;
      end
      b++;
      if (b == 8) begin
        b = 0; c++;
        if (c == COLS) begin
          c = 0; s++;
          if (s == SCANS) begin
            s = 0; r++;
            if (r == ROWS) r = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (beep_vld) begin
        total++;
        if (beep_o !== beep_exp) begin
          fails++;
          $display("FAIL R9 beep_o=%b expected %b", beep_o, beep_exp);
        end
      end
      if (!rst && va_chk) begin
        va_chk = 0;
        total++;
        if (int'(vram_addr) != va_exp) begin
          fails++;
          $display("FAIL R2 vram_addr=%0d expected %0d", vram_addr, va_exp);
        end
      end
      if (!rst && exq.size() > 0) begin
        int e;
        logic [3:0] act, ex;
        e  = exq.pop_front();
        ex = 4'(e % 16);
        act = {frame_o, hsync_o, blank_o, pix_o};
        if (ex[3]) fs_exp++;
        if (frame_o === 1'b1) fs_seen++;
        total++;
        if (act !== ex) begin
          fails++;
          $display("FAIL %s/R6/R7 fs,hs,blank,pix=%b expected %b", tagname(e / 16), act, ex);
        end
      end
    end
  end

  task automatic set_ctrl(input logic [7:0] v);
    @(posedge clk);
    #2 ctrl = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    repeat (2 * FRAME) @(posedge clk);
    set_ctrl(8'h08);                 // R4 256 mode, alternate inactive
    repeat (FRAME + 3) @(posedge clk);
    set_ctrl(8'h00);                 // R4 256 mode, all inverted
    repeat (FRAME + 5) @(posedge clk);
    set_ctrl(8'h10);                 // R5 128 mode, alt bit ignored
    repeat (FRAME + 1) @(posedge clk);
    set_ctrl(8'h38);
    repeat (FRAME) @(posedge clk);
    // R7: control changes at arbitrary cycles, often mid-cell
    for (int i = 0; i < 300; i++) begin
      set_ctrl(8'($urandom));
      repeat ($urandom_range(0, 10)) @(posedge clk);
    end
    // R1: second reset in mid-frame
    @(posedge clk);
    #2 rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    ctrl = 8'h28;
    repeat (FRAME + 20) @(posedge clk);
    @(negedge clk);
    // R8: one pulse per frame, all counted
    total++;
    if (fs_seen != fs_exp || fs_exp < 6) begin
      fails++;
      $display("FAIL R8 frame pulses=%0d expected %0d", fs_seen, fs_exp);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired expected completion");
      finish_run();
    end
  end
endmodule